// File: doc/BRIEF.md
# Parameterised Fixed-Point Rounding Stage

This block narrows a signed two's-complement sample from a wide input word to a narrower output word, discarding low-order bits under one of four rounding policies fixed at build time: plain truncation, round half up, round half away from zero, and convergent rounding (ties go to the even neighbour). It sits between arithmetic stages of a datapath, for instance after a multiplier or adder whose growth in precision must be trimmed before the next stage.

The result is registered, so the stage adds exactly one clock of delay. A clock enable gates the register, and a companion sync flag travels through an identical register so that it stays aligned with the data. No saturation is applied: when rounding up from the largest positive kept value, the result wraps to the most negative value.

Top module: `fxround_stage`

## Requirements
- R1: With `ce` high at a rising edge and `rst` low, `dout` after that edge equals the rounded value of the `din` present at that edge (one cycle of latency).
- R2: In truncation mode (`MODE = RND_TRUNC`), `dout` is `din` with its low `IN_W-OUT_W` bits dropped, i.e. the floor of the scaled value.
- R3: In round-half-up mode (`RND_HALF_UP`), the kept field is incremented exactly when the highest discarded bit is 1, regardless of sign.
- R4: In away-from-zero mode (`RND_AWAY`), an exact half (highest discarded bit 1, all lower discarded bits 0) increments the kept field for a non-negative input and leaves it unchanged for a negative input; other values round to the nearest.
- R5: In convergent mode (`RND_EVEN`), an exact half increments the kept field only when its least significant bit is 1, so the result bit 0 is 0; other values round to the nearest.
- R6: In every mode, when the highest discarded bit is 0 the output equals the kept field unchanged.
- R7: With `ce` low, `dout` and `sync_out` keep their previous values.
- R8: A synchronous active-high `rst` clears `dout` and `sync_out` to zero at the next rising edge, overriding `ce`.
- R9: `sync_out` after an enabled edge equals the `sync_in` sampled at that edge.
- R10: An increment of the largest positive kept value wraps to the most negative output value; no saturation occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for the output register |
| din | input | IN_W | Signed two's-complement input sample |
| sync_in | input | 1 | Marker flag travelling with the sample |
| dout | output | OUT_W | Rounded signed output sample |
| sync_out | output | 1 | Marker flag delayed to match `dout` |

## Verification
The assertions assume `din`, `sync_in` and `ce` are known and settled at each rising edge, and that their one-cycle-back comparisons are meaningful only once reset has been released; the bench drives every input on the falling edge and always starts with a reset pulse. The mode-specific properties take the discarded field's tie pattern as the trigger, so the stimulus mixes random words with directed exact halves of both signs and both kept-field parities, plus the largest positive kept value with a half to reach the wrap case. Enable-low stretches and a reset asserted mid-stream are placed between enabled cycles so the hold and clear properties see non-trivial prior values.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    typedef enum logic [1:0] {
        RND_TRUNC   = 2'd0,
        RND_HALF_UP = 2'd1,
        RND_AWAY    = 2'd2,
        RND_EVEN    = 2'd3
    } rnd_mode_e;

    // Fields extracted from the discarded part of a sample
    typedef struct packed {
        logic sign;
        logic guard;
        logic sticky;
        logic kept_lsb;
    } rnd_flags_t;

    // Nearest-value rounding with a caller-supplied tie decision
    function automatic logic near_inc(input logic guard, input logic sticky,
                                      input logic tie_up);
        return guard & (sticky | tie_up);
    endfunction

endpackage

// File: rtl/rnd_split.sv
module rnd_split #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] kept,
    output rnd_pkg::rnd_flags_t flags
);
    localparam int DROP_W = IN_W - OUT_W;

    logic sticky_w;

    generate
        if (DROP_W > 1) begin : g_sticky
            assign sticky_w = |din[DROP_W-2:0];
        end else begin : g_no_sticky
            assign sticky_w = 1'b0;
        end
    endgenerate

    assign kept           = din[IN_W-1:DROP_W];
    assign flags.sign     = din[IN_W-1];
    assign flags.guard    = din[DROP_W-1];
    assign flags.sticky   = sticky_w;
    assign flags.kept_lsb = din[DROP_W];

endmodule

// File: rtl/rnd_decide.sv
module rnd_decide #(
    parameter rnd_pkg::rnd_mode_e MODE = rnd_pkg::RND_EVEN
) (
    input  rnd_pkg::rnd_flags_t flags,
    output logic                inc
);
    import rnd_pkg::*;

    generate
        if (MODE == RND_TRUNC) begin : g_trunc
            assign inc = 1'b0;
        end else if (MODE == RND_HALF_UP) begin : g_half_up
            assign inc = flags.guard;
        end else if (MODE == RND_AWAY) begin : g_away
            // non-negative ties go up, negative ties stay (more negative)
            assign inc = near_inc(flags.guard, flags.sticky, ~flags.sign);
        end else begin : g_even
            // ties go up only when the kept field is odd
            assign inc = near_inc(flags.guard, flags.sticky, flags.kept_lsb);
        end
    endgenerate

endmodule

// File: rtl/rnd_outreg.sv
module rnd_outreg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] d,
    input  logic         sync_d,
    output logic [W-1:0] q,
    output logic         sync_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            sync_q <= 1'b0;
        end else if (ce) begin
            q      <= d;
            sync_q <= sync_d;
        end
    end

endmodule

// File: rtl/fxround_stage.sv
module fxround_stage #(
    parameter int                 IN_W  = 16,
    parameter int                 OUT_W = 12,
    parameter rnd_pkg::rnd_mode_e MODE  = rnd_pkg::RND_EVEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [IN_W-1:0]  din,
    input  logic             sync_in,
    output logic [OUT_W-1:0] dout,
    output logic             sync_out
);
    localparam int DROP_W = IN_W - OUT_W;

    initial begin
        if (DROP_W < 1) $error("fxround_stage: OUT_W must be below IN_W");
    end

    logic [OUT_W-1:0]    kept;
    rnd_pkg::rnd_flags_t flags;
    logic                inc;
    logic [OUT_W-1:0]    rounded;

    rnd_split #(.IN_W(IN_W), .OUT_W(OUT_W)) u_split (
        .din   (din),
        .kept  (kept),
        .flags (flags)
    );

    rnd_decide #(.MODE(MODE)) u_decide (
        .flags (flags),
        .inc   (inc)
    );

    // wraps on overflow: no saturation
    assign rounded = kept + {{(OUT_W-1){1'b0}}, inc};

    rnd_outreg #(.W(OUT_W)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .d      (rounded),
        .sync_d (sync_in),
        .q      (dout),
        .sync_q (sync_out)
    );

endmodule

// File: rtl/fxround_chk.sv
module fxround_chk #(
    parameter int                 IN_W  = 16,
    parameter int                 OUT_W = 12,
    parameter rnd_pkg::rnd_mode_e MODE  = rnd_pkg::RND_EVEN
) (
    input logic             clk,
    input logic             rst,
    input logic             ce,
    input logic [IN_W-1:0]  din,
    input logic             sync_in,
    input logic [OUT_W-1:0] dout,
    input logic             sync_out
);
    import rnd_pkg::*;
    localparam int DROP_W = IN_W - OUT_W;
    localparam logic [IN_W-1:0] LOW_MASK = (IN_W'(1) << (DROP_W-1)) - IN_W'(1);

    logic [OUT_W-1:0] k_c;
    logic             g_c, s_c, neg_c;
    assign k_c   = din[IN_W-1:DROP_W];
    assign g_c   = din[DROP_W-1];
    assign s_c   = |(din & LOW_MASK);
    assign neg_c = din[IN_W-1];

    // R1 R10
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        ce |=> (dout == $past(k_c)) || (dout == $past(k_c) + 1'b1));

    // R6
    below_half_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && !g_c) |=> dout == $past(k_c));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(dout) && $stable(sync_out));

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dout == '0) && !sync_out);

    // R9
    sync_align_chk: assert property (@(posedge clk) disable iff (rst)
        ce |=> sync_out == $past(sync_in));

    generate
        if (MODE == RND_TRUNC) begin : g_trunc
            // R2
            trunc_chk: assert property (@(posedge clk) disable iff (rst)
                ce |=> dout == $past(k_c));
        end else if (MODE == RND_HALF_UP) begin : g_half_up
            // R3
            half_up_chk: assert property (@(posedge clk) disable iff (rst)
                (ce && g_c) |=> dout == $past(k_c) + 1'b1);
        end else if (MODE == RND_AWAY) begin : g_away
            // R4
            away_neg_chk: assert property (@(posedge clk) disable iff (rst)
                (ce && g_c && !s_c && neg_c) |=> dout == $past(k_c));
            // R4
            away_pos_chk: assert property (@(posedge clk) disable iff (rst)
                (ce && g_c && !neg_c) |=> dout == $past(k_c) + 1'b1);
        end else begin : g_even
            // R5
            even_tie_chk: assert property (@(posedge clk) disable iff (rst)
                (ce && g_c && !s_c) |=> !dout[0]);
        end
    endgenerate

endmodule

bind fxround_stage fxround_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .MODE(MODE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .din      (din),
    .sync_in  (sync_in),
    .dout     (dout),
    .sync_out (sync_out)
);

// File: tb/sim_fxround_stage.sv
module sim_fxround_stage;
    localparam int IN_W  = 16;
    localparam int OUT_W = 12;
    localparam int D     = IN_W - OUT_W;
    localparam longint OMASK = (longint'(1) << OUT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ce  = 1'b0;
    logic [IN_W-1:0]  din = '0;
    logic             sync_in = 1'b0;
    logic [OUT_W-1:0] dout [4];
    logic             sync_out [4];

    longint exp_d [4];
    logic   exp_s;
    int     vectors = 0;
    int     miscompares = 0;
    bit     done = 0;
    string  mode_tag [4] = '{"R2", "R3", "R4", "R5"};

    always #10 clk = ~clk;   // 50 MHz

    for (genvar m = 0; m < 4; m++) begin : g_mode
        localparam rnd_pkg::rnd_mode_e M = rnd_pkg::rnd_mode_e'(m);
        fxround_stage #(.IN_W(IN_W), .OUT_W(OUT_W), .MODE(M)) u0 (
            .clk      (clk),
            .rst      (rst),
            .ce       (ce),
            .din      (din),
            .sync_in  (sync_in),
            .dout     (dout[m]),
            .sync_out (sync_out[m])
        );
    end

    // Behavioural reference: integer floor, remainder, tie handling
    function automatic longint ref_round(input logic [IN_W-1:0] v, input int mode);
        longint x, q, rem, half;
        bit up;
        x    = longint'($signed(v));
        q    = x >>> D;
        rem  = x - (q * (longint'(1) << D));
        half = longint'(1) << (D - 1);
        case (mode)
            0:       up = 0;
            1:       up = (rem >= half);
            2:       up = (rem > half) || (rem == half && x >= 0);
            default: up = (rem > half) || (rem == half && (q % 2 != 0));
        endcase
        return (q + (up ? 1 : 0)) & OMASK;
    endfunction

    // drive on the falling edge, model the rising edge, compare on the next fall
    task automatic step(input logic r, input logic e, input logic [IN_W-1:0] v,
                        input logic s, input string tag);
        rst = r; ce = e; din = v; sync_in = s;
        for (int m = 0; m < 4; m++) begin
            if (r)      exp_d[m] = 0;
            else if (e) exp_d[m] = ref_round(v, m);
        end
        if (r)      exp_s = 0;
        else if (e) exp_s = s;
        @(negedge clk);
        for (int m = 0; m < 4; m++) begin
            vectors++;
            if (longint'(dout[m]) != exp_d[m] || sync_out[m] !== exp_s) begin
                miscompares++;
                $display("FAIL %s %s mode %0d din=%h: dout=%h sync=%b expected %h sync=%b",
                         tag, mode_tag[m], m, v, dout[m], sync_out[m], exp_d[m][OUT_W-1:0], exp_s);
            end
        end
    endtask

    initial begin
        @(negedge clk);
        // R8: reset state
        step(1, 0, '0, 1, "R8");
        // R1 R6: below half, all modes keep the field
        step(0, 1, 16'h1237, 1, "R6");
        step(0, 1, 16'hF234, 0, "R6");
        // R3 R4 R5: exact halves, both signs, both parities
        step(0, 1, 16'h0028, 1, "R1");   // +2.5 even kept
        step(0, 1, 16'h0038, 0, "R1");   // +3.5 odd kept
        step(0, 1, 16'hFFD8, 1, "R4");   // -2.5 odd kept (q=-3)
        step(0, 1, 16'hFFC8, 0, "R5");   // -3.5 even kept (q=-4)
        // above half
        step(0, 1, 16'h002C, 1, "R1");
        step(0, 1, 16'hFFDC, 0, "R1");
        // R10: largest positive kept value with a half and above
        step(0, 1, 16'h7FF8, 1, "R10");
        step(0, 1, 16'h7FFF, 0, "R10");
        // R7: enable low holds output and sync
        step(0, 0, 16'h1234, 1, "R7");
        step(0, 0, 16'h5558, 1, "R7");
        // R9: sync follows after enable returns
        step(0, 1, 16'h4444, 1, "R9");
        step(0, 1, 16'h4448, 0, "R9");
        // R8: mid-stream reset overrides enable
        step(1, 1, 16'h3338, 1, "R8");
        step(0, 1, 16'h8008, 1, "R2");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [IN_W-1:0] v;
            v = IN_W'($urandom);
            if (i % 5 == 0) v[D-1:0] = 4'b1000;   // force ties
            step(0, (i % 7) != 3, v, 1'($urandom), "R1");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule